// File: doc/BRIEF.md
# Packet FIFO with Watermark Backpressure

This block is a packet-aware buffer placed between a packet source and a downstream packet consumer. Each word carries a start flag and an end flag. As the store fills, the block first asks the source to pause. If the source keeps sending and the fill climbs further, the block stops taking input.

When it stops, the block closes any packet it has only partly stored by inserting a terminating word marked as errored. The consumer therefore always receives well-formed packets, and it can discard the damaged one. Sticky overflow and error status bits record the event until they are cleared with a write-one pulse.

The store holds four times a base depth. Every threshold is derived from that depth: pause at 5/8, release at 1/2, halt at 3/4. The output is a registered valid/ready stage fed from a synchronously read memory.

Top module: `pkt_wm_fifo`

## Requirements
- R1: After reset, out_valid, in_bp, sts_ovf, sts_err and sts_halt are 0 and sts_level is 0.
- R2: Accepted words leave in arrival order with data, out_sop and out_eop unchanged and out_err 0. While out_valid is 1 and out_ready is 0, the presented word stays stable.
- R3: in_bp becomes 1 one cycle after sts_level reaches DEPTH*5/8 (10 for DEPTH 16). It becomes 0 one cycle after sts_level falls below DEPTH/2 (8); between those levels it keeps its value.
- R4: In a cycle where sts_halt is 0 and sts_level is at least DEPTH*3/4 (12), an overflow event occurs. The input word presented in that cycle is dropped, and sts_ovf, sts_err and sts_halt read 1 from the next cycle.
- R5: If a packet is partly stored at the overflow event, one extra word is stored after its last accepted word, with data 0, sop 0, eop 1 and err 1. If no packet is open, nothing is added.
- R6: While halted, words with sop 0 are dropped, and so are words with sop 1 while sts_level is at least DEPTH*5/8. A word with sop 1 presented while sts_level is below that mark is accepted and clears the halt.
- R7: sts_ovf and sts_err hold their value until a one-cycle pulse on clr_ovf or clr_err, respectively, clears only that bit on the next cycle.
- R8: The store holds DEPTH = 4*BASE_DEPTH words. sts_level counts the stored words, excluding the word presented on the output, and never exceeds DEPTH*3/4 + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_data | input | DW | Input payload |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| in_bp | output | 1 | Request to the source to pause |
| out_valid | output | 1 | Output word present |
| out_data | output | DW | Output payload |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |
| out_err | output | 1 | Output word closes a truncated packet |
| out_ready | input | 1 | Consumer takes the output word |
| clr_ovf | input | 1 | Write-one pulse clearing sts_ovf |
| clr_err | input | 1 | Write-one pulse clearing sts_err |
| sts_ovf | output | 1 | Sticky overflow status |
| sts_err | output | 1 | Sticky error status |
| sts_halt | output | 1 | Input admission is halted |
| sts_level | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The bench builds the block with DW 8 and BASE_DEPTH 4, so DEPTH is 16 and the marks fall at 8, 10 and 12 words. With such a small store, a few directed packets reach every mark. This makes it practical to check the hysteresis band word by word and the halt with and without an open packet. It also reaches the case where a start word arrives during the halt but above the release mark.

// File: rtl/pkt_wm_pkg.sv
package pkt_wm_pkg;
  typedef struct packed {
    logic err;
    logic sop;
    logic eop;
  } pw_flags_t;
  localparam int FLAG_W = 3;
endpackage

// File: rtl/pf_store.sv
module pf_store
  import pkt_wm_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int LVL_CAP = 13,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int EW     = DW + FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  pw_flags_t     wflg,
  output logic [CW-1:0] level,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output pw_flags_t     out_flg,
  input  logic          out_ready
);
  logic [EW-1:0] mem [0:DEPTH-1];
  logic [EW-1:0] rd_q;
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          vld_q;
  logic          pop;

  assign pop = (cnt != '0) && (!vld_q || out_ready);

  // storage with synchronous read, suited to block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wflg, wdata};
  end

  always_ff @(posedge clk) begin
    if (pop) rd_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (pop)            vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
    end
  end

  assign level     = cnt;
  assign out_valid = vld_q;
  assign out_data  = rd_q[DW-1:0];
  assign out_flg   = pw_flags_t'(rd_q[EW-1:DW]);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !out_ready) |=> (vld_q && $stable(rd_q))); // R2
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LVL_CAP)); // R8
endmodule

// File: rtl/pf_level.sv
module pf_level #(
  parameter int DEPTH = 16,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int BP_ON  = (DEPTH * 5) / 8,
  localparam int BP_OFF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level,
  output logic          bp
);
  logic bp_q;

  always_ff @(posedge clk) begin
    if (rst)                         bp_q <= 1'b0;
    else if (level >= CW'(BP_ON))    bp_q <= 1'b1;
    else if (level <  CW'(BP_OFF))   bp_q <= 1'b0;
  end

  assign bp = bp_q;

  AST_BP_RISE: assert property (@(posedge clk) disable iff (rst)
    (level >= CW'(BP_ON)) |=> bp_q); // R3
  AST_BP_FALL: assert property (@(posedge clk) disable iff (rst)
    (level < CW'(BP_OFF)) |=> !bp_q); // R3
endmodule

// File: rtl/pf_admit.sv
module pf_admit
  import pkt_wm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int HALT_AT = (DEPTH * 3) / 4,
  localparam int REOPEN  = (DEPTH * 5) / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          push,
  output logic [DW-1:0] wdata,
  output pw_flags_t     wflg,
  output logic          halted,
  output logic          ovf_evt
);
  logic halt_q, open_q;
  logic trig, resume;

  assign trig   = !halt_q && (level >= CW'(HALT_AT));
  assign resume = halt_q && in_valid && in_sop && (level < CW'(REOPEN));

  always_comb begin
    push  = 1'b0;
    wdata = in_data;
    wflg  = '{err: 1'b0, sop: in_sop, eop: in_eop};
    if (trig) begin
      // close the partly stored packet with an errored terminator
      push  = open_q;
      wdata = '0;
      wflg  = '{err: 1'b1, sop: 1'b0, eop: 1'b1};
    end else if (halt_q) begin
      push = resume;
    end else begin
      push = in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      open_q <= 1'b0;
    end else if (trig) begin
      halt_q <= 1'b1;
      open_q <= 1'b0;
    end else begin
      if (resume) halt_q <= 1'b0;
      if (push)   open_q <= !in_eop;
    end
  end

  assign halted  = halt_q;
  assign ovf_evt = trig;

  AST_HALT_ENTER: assert property (@(posedge clk) disable iff (rst)
    (!halt_q && level >= CW'(HALT_AT)) |=> halt_q); // R4
  AST_HALT_DROP: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !(in_valid && in_sop)) |-> !push); // R6
endmodule

// File: rtl/pkt_wm_fifo.sv
module pkt_wm_fifo
  import pkt_wm_pkg::*;
#(
  parameter int DW         = 8,
  parameter int BASE_DEPTH = 4,
  localparam int DEPTH     = 4 * BASE_DEPTH,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int LVL_CAP   = (DEPTH * 3) / 4 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          in_bp,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_err,
  input  logic          out_ready,
  input  logic          clr_ovf,
  input  logic          clr_err,
  output logic          sts_ovf,
  output logic          sts_err,
  output logic          sts_halt,
  output logic [CW-1:0] sts_level
);
  logic          push, ovf_evt, halted;
  logic [DW-1:0] wdata;
  pw_flags_t     wflg, oflg;
  logic [CW-1:0] level;
  logic          ovf_q, err_q;

  pf_admit #(.DW(DW), .DEPTH(DEPTH)) u_admit (
    .clk(clk), .rst(rst), .level(level),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .push(push), .wdata(wdata), .wflg(wflg), .halted(halted), .ovf_evt(ovf_evt)
  );

  pf_store #(.DW(DW), .DEPTH(DEPTH), .LVL_CAP(LVL_CAP)) u_store (
    .clk(clk), .rst(rst), .push(push), .wdata(wdata), .wflg(wflg),
    .level(level), .out_valid(out_valid), .out_data(out_data),
    .out_flg(oflg), .out_ready(out_ready)
  );

  pf_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst), .level(level), .bp(in_bp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ovf_evt)      ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
      if (ovf_evt)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  assign out_sop   = oflg.sop;
  assign out_eop   = oflg.eop;
  assign out_err   = oflg.err;
  assign sts_ovf   = ovf_q;
  assign sts_err   = err_q;
  assign sts_halt  = halted;
  assign sts_level = level;

  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (ovf_q && err_q && halted)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_ovf) |=> ovf_q); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_err) |=> err_q); // R7
endmodule

// File: tb/pkt_wm_fifo_bench.sv
`timescale 1ns/1ps
module pkt_wm_fifo_bench;
  localparam int DW = 8;
  localparam int BASE_DEPTH = 4;
  localparam int CW = $clog2(4 * BASE_DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_ready = 1'b0, clr_ovf = 1'b0, clr_err = 1'b0;
  logic in_bp, out_valid, out_sop, out_eop, out_err, sts_ovf, sts_err, sts_halt;
  logic [DW-1:0] out_data;
  logic [CW-1:0] sts_level;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] rx_d [0:63];
  logic rx_s [0:63];
  logic rx_e [0:63];
  logic rx_x [0:63];
  int rx_n = 0;

  always #4 clk = ~clk;

  pkt_wm_fifo #(.DW(DW), .BASE_DEPTH(BASE_DEPTH)) u_pkt_wm_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_bp(in_bp),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_err(out_err), .out_ready(out_ready),
    .clr_ovf(clr_ovf), .clr_err(clr_err), .sts_ovf(sts_ovf),
    .sts_err(sts_err), .sts_halt(sts_halt), .sts_level(sts_level)
  );

  // record each word handed over at the coming edge
  always @(negedge clk) begin
    if (rst) rx_n = 0;
    else if (out_valid && out_ready && rx_n < 64) begin
      rx_d[rx_n] = out_data;
      rx_s[rx_n] = out_sop;
      rx_e[rx_n] = out_eop;
      rx_x[rx_n] = out_err;
      rx_n++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [DW-1:0] d, input logic s, input logic e);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    tick();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; clr_ovf = 1'b0; clr_err = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_bp", in_bp, 0);
    chk("R1 sts_ovf", sts_ovf, 0);
    chk("R1 sts_err", sts_err, 0);
    chk("R1 sts_halt", sts_halt, 0);
    chk("R1 sts_level", sts_level, 0);
  endtask

  task automatic t_pass();
    do_reset();
    out_ready = 1'b1;
    put(8'hB1, 1, 0); put(8'hB2, 0, 0); put(8'hB3, 0, 1);
    repeat (4) tick();
    chk("R2 count", rx_n, 3);
    chk("R2 order first", rx_d[0], 8'hB1);
    chk("R2 sop", rx_s[0], 1);
    chk("R2 order last", rx_d[2], 8'hB3);
    chk("R2 eop", rx_e[2], 1);
    chk("R2 no err", rx_x[2], 0);
  endtask

  task automatic t_hold();
    do_reset();
    put(8'hA1, 1, 0); put(8'hA2, 0, 1);
    tick();
    chk("R8 level one stored", sts_level, 1);
    chk("R2 valid held", out_valid, 1);
    repeat (3) tick();
    chk("R2 data held", out_data, 8'hA1);
    chk("R2 sop held", out_sop, 1);
    out_ready = 1'b1;
    repeat (3) tick();
    chk("R2 drained count", rx_n, 2);
    chk("R2 second word", rx_d[1], 8'hA2);
  endtask

  task automatic t_bp();
    do_reset();
    for (int i = 0; i < 11; i++) put(DW'(i), i == 0, 0);
    chk("R8 level after 11", sts_level, 10);
    chk("R3 bp lags one cycle", in_bp, 0);
    tick();
    chk("R3 bp set at 5/8", in_bp, 1);
    out_ready = 1'b1;
    tick();
    chk("R3 hold at 9", in_bp, 1);
    tick(); tick();
    chk("R8 level 7", sts_level, 7);
    chk("R3 bp still set at 7", in_bp, 1);
    tick();
    chk("R3 bp clear below 1/2", in_bp, 0);
    out_ready = 1'b0;
  endtask

  task automatic t_ovf_open();
    do_reset();
    in_valid = 1'b1;
    for (int i = 0; i < 13; i++) put(DW'(i), i == 0, 0);
    chk("R4 level at mark", sts_level, 12);
    chk("R4 no halt yet", sts_halt, 0);
    chk("R4 no ovf yet", sts_ovf, 0);
    put(8'd13, 0, 0);
    chk("R5 forced word added", sts_level, 13);
    chk("R4 ovf set", sts_ovf, 1);
    chk("R4 err set", sts_err, 1);
    chk("R4 halt set", sts_halt, 1);
    put(8'd14, 0, 0);
    chk("R6 drop while halted", sts_level, 13);
    out_ready = 1'b1;
    repeat (16) tick();
    out_ready = 1'b0;
    chk("R4 word count", rx_n, 14);
    chk("R2 first sop", rx_s[0], 1);
    chk("R4 last real word", rx_d[12], 12);
    chk("R5 forced data", rx_d[13], 0);
    chk("R5 forced eop", rx_e[13], 1);
    chk("R5 forced err", rx_x[13], 1);
    chk("R5 forced sop", rx_s[13], 0);
    put(8'h33, 0, 1);
    tick();
    chk("R6 non-start dropped", sts_level, 0);
    chk("R6 still halted", sts_halt, 1);
    out_ready = 1'b1;
    put(8'hAA, 1, 1);
    chk("R6 halt released", sts_halt, 0);
    repeat (3) tick();
    chk("R6 resumed count", rx_n, 15);
    chk("R6 resumed data", rx_d[14], 8'hAA);
    out_ready = 1'b0;
  endtask

  task automatic t_ovf_closed();
    int errs;
    do_reset();
    for (int i = 0; i < 13; i++) put(DW'(8'h10 + i), 1, 1);
    tick();
    chk("R5 no forced word", sts_level, 12);
    chk("R4 halt closed case", sts_halt, 1);
    put(8'h77, 1, 1);
    chk("R6 start above mark dropped", sts_level, 12);
    repeat (3) tick();
    chk("R7 ovf sticky", sts_ovf, 1);
    clr_ovf = 1'b1; tick(); clr_ovf = 1'b0;
    chk("R7 ovf cleared", sts_ovf, 0);
    chk("R7 err kept", sts_err, 1);
    clr_err = 1'b1; tick(); clr_err = 1'b0;
    chk("R7 err cleared", sts_err, 0);
    out_ready = 1'b1;
    repeat (3) tick();
    out_ready = 1'b0;
    chk("R8 level after 3 pops", sts_level, 9);
    put(8'h55, 1, 1);
    chk("R6 start below mark resumes", sts_halt, 0);
    chk("R8 level after resume", sts_level, 10);
    out_ready = 1'b1;
    repeat (15) tick();
    out_ready = 1'b0;
    chk("R6 total delivered", rx_n, 14);
    chk("R6 resumed word", rx_d[13], 8'h55);
    chk("R2 last held word", rx_d[12], 8'h1C);
    errs = 0;
    for (int i = 0; i < 14; i++) errs += int'(rx_x[i]);
    chk("R5 no err flags", errs, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    t_reset_state();
    t_pass();
    t_hold();
    t_bp();
    t_ovf_open();
    t_ovf_closed();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog all: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule